// File: doc/BRIEF.md
# UART Hardware Flow Controller

This block automates request-to-send / clear-to-send flow control for a single UART channel. On the receive side it compares the receive FIFO fill level against two programmable limits. It pulls the active-low RTS line inactive when the FIFO is getting full, and pulls it active again once software has drained the FIFO far enough. The two limits are packed into one 8-bit threshold byte as 4-bit nibbles, each counting in steps of four FIFO entries. The gap between them forms a hysteresis window, so RTS does not chatter around a single level.

On the transmit side it gates the start of every new character on the active-low CTS input. The transmitter raises a check request at each character boundary, which is the midpoint of the last stop bit or the idle state while it waits. CTS is resynchronised and sampled only on those cycles. The resulting permit is then held until the next boundary, so a CTS change in the middle of a character never cuts it short.

The block also signals RTS or CTS moving from active to inactive as a one-cycle interrupt request. It reports ordinary CTS changes to the modem-status logic only while automatic CTS handling is off. Each automatic function has its own enable, and either can be used without the other.

Top module: `uart_hfc_top`

## Requirements
- R1: After reset, rts_n is 1 and flow_irq and mdm_cts_chg are 0. With auto_cts_en at 0, tx_permit is 1. With auto_cts_en at 1, tx_permit is 0 until the first boundary check.
- R2: The halt level is thresh[3:0] times 4 and the resume level is thresh[7:4] times 4, both in FIFO entries. For example, 0x8F gives halt 60 and resume 32, and 0x2D gives halt 52 and resume 8.
- R3: With auto_rts_en at 1, a rx_level at or above the halt level drives rts_n to 1 after the next rising clock edge.
- R4: After a halt, rts_n returns to 0 only when rx_level is at or below the resume level. A level strictly between the resume and halt levels keeps the current rts_n.
- R5: With auto_rts_en at 0, rts_n equals the inverse of rts_manual, one clock edge after rts_manual is applied.
- R6: With auto_cts_en at 1, tx_permit is updated only at clock edges where tx_check is 1, and then takes the inverse of the resynchronised cts_n. CTS passes through a two-flop synchroniser. At all other edges tx_permit holds its value.
- R7: With auto_cts_en at 0, tx_permit is 1 regardless of cts_n and tx_check.
- R8: flow_irq pulses high for one cycle when rts_n goes from 0 to 1, or when the resynchronised cts_n goes from 0 to 1. The pulse appears one edge after the rts_n change and three edges after a cts_n change. If both changes happen together, they give a single pulse.
- R9: mdm_cts_chg pulses for one cycle on any change of the resynchronised cts_n, three edges after the pin change, but only while auto_cts_en is 0. While auto_cts_en is 1 it stays at 0.
- R10: A drop of rx_level to 0, as after a FIFO clear, re-asserts rts_n (drives it to 0) after the next edge, even from the halted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_level | input | LVL_W | Current receive FIFO fill level in entries |
| thresh | input | 8 | Resume nibble [7:4], halt nibble [3:0], each in steps of four entries |
| auto_rts_en | input | 1 | Enables automatic RTS control |
| rts_manual | input | 1 | Software RTS request used when automatic RTS is off (1 drives rts_n low) |
| auto_cts_en | input | 1 | Enables CTS gating of the transmitter |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_check | input | 1 | Transmitter is at a character boundary and asks for permission |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_permit | output | 1 | 1 allows the transmitter to start the next character |
| flow_irq | output | 1 | One-cycle pulse when RTS or CTS goes inactive |
| mdm_cts_chg | output | 1 | One-cycle CTS change pulse for modem-status reporting |

## Verification
The two events that can land in the same cycle are an RTS halt, caused by the receive level crossing the halt threshold, and a CTS deassertion emerging from the synchroniser. Both feed the single interrupt request. The bench provokes the collision by raising cts_n one cycle before it steps rx_level onto the halt level, so that both edge detectors fire together. It then checks that flow_irq is high for exactly one cycle at the predicted edge and low on the cycles before and after. The gating of tx_permit against CTS changes between boundary checks is judged the same way, cycle by cycle.

// File: rtl/uart_hfc_pkg.sv
package uart_hfc_pkg;

  // Hysteresis state of the receive-side flow control.
  typedef enum logic {
    FLOW_ON = 1'b0,
    HALTED  = 1'b1
  } rx_flow_e;

  // Width of each threshold nibble inside the threshold byte.
  localparam int unsigned NIB_W = 4;

endpackage

// File: rtl/uart_hfc_sync.sv
module uart_hfc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/uart_hfc_rts.sv
module uart_hfc_rts
  import uart_hfc_pkg::*;
#(
  parameter int unsigned LVL_W      = 7,
  parameter int unsigned STEP_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             manual,
  input  logic [LVL_W-1:0] level,
  input  logic [NIB_W-1:0] halt_nib,
  input  logic [NIB_W-1:0] resume_nib,
  output logic             rts_n
);

  logic [LVL_W-1:0] halt_lvl;
  logic [LVL_W-1:0] resume_lvl;
  rx_flow_e         state_q;
  rx_flow_e         state_d;
  logic             rts_n_q;
  logic             rts_n_d;

  // Nibbles count in steps of 2**STEP_SHIFT entries.
  assign halt_lvl   = LVL_W'(halt_nib)   << STEP_SHIFT;
  assign resume_lvl = LVL_W'(resume_nib) << STEP_SHIFT;

  always_comb begin
    state_d = state_q;
    if (!auto_en) begin
      state_d = FLOW_ON;
    end else if (level >= halt_lvl) begin
      state_d = HALTED;
    end else if (level <= resume_lvl) begin
      state_d = FLOW_ON;
    end
    rts_n_d = auto_en ? (state_d == HALTED) : ~manual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FLOW_ON;
      rts_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      rts_n_q <= rts_n_d;
    end
  end

  assign rts_n = rts_n_q;

endmodule

// File: rtl/uart_hfc_cts.sv
module uart_hfc_cts (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic cts_s,
  input  logic tx_check,
  output logic tx_permit
);

  logic permit_q;
  logic permit_d;
  logic permit_en;

  // The permit register loads only at character boundaries.
  assign permit_en = ~auto_en | tx_check;

  always_comb begin
    permit_d = permit_q;
    if (permit_en) begin
      permit_d = auto_en ? ~cts_s : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      permit_q <= 1'b0;
    end else begin
      permit_q <= permit_d;
    end
  end

  assign tx_permit = ~auto_en | permit_q;

endmodule

// File: rtl/uart_hfc_evt.sv
module uart_hfc_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_n,
  input  logic cts_s,
  input  logic auto_cts_en,
  output logic flow_irq,
  output logic mdm_cts_chg
);

  logic rts_prev_q;
  logic cts_prev_q;
  logic irq_q;
  logic irq_d;
  logic chg_q;
  logic chg_d;

  always_comb begin
    irq_d = (rts_n & ~rts_prev_q) | (cts_s & ~cts_prev_q);
    chg_d = ~auto_cts_en & (cts_s ^ cts_prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_prev_q <= 1'b1;
      cts_prev_q <= 1'b1;
      irq_q      <= 1'b0;
      chg_q      <= 1'b0;
    end else begin
      rts_prev_q <= rts_n;
      cts_prev_q <= cts_s;
      irq_q      <= irq_d;
      chg_q      <= chg_d;
    end
  end

  assign flow_irq    = irq_q;
  assign mdm_cts_chg = chg_q;

endmodule

// File: rtl/uart_hfc_top.sv
module uart_hfc_top
  import uart_hfc_pkg::*;
#(
  parameter int unsigned LVL_W       = 7,
  parameter int unsigned STEP_SHIFT  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [7:0]       thresh,
  input  logic             auto_rts_en,
  input  logic             rts_manual,
  input  logic             auto_cts_en,
  input  logic             cts_n,
  input  logic             tx_check,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             flow_irq,
  output logic             mdm_cts_chg
);

  localparam int unsigned RST_STAGES = 2;

  logic rst_sync_n;
  logic cts_s;

  uart_hfc_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (rst_sync_n)
  );

  uart_hfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk    (clk),
    .arst_n (rst_sync_n),
    .d      (cts_n),
    .q      (cts_s)
  );

  uart_hfc_rts #(.LVL_W(LVL_W), .STEP_SHIFT(STEP_SHIFT)) u_rts (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .auto_en    (auto_rts_en),
    .manual     (rts_manual),
    .level      (rx_level),
    .halt_nib   (thresh[NIB_W-1:0]),
    .resume_nib (thresh[2*NIB_W-1:NIB_W]),
    .rts_n      (rts_n)
  );

  uart_hfc_cts u_cts (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .auto_en   (auto_cts_en),
    .cts_s     (cts_s),
    .tx_check  (tx_check),
    .tx_permit (tx_permit)
  );

  uart_hfc_evt u_evt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rts_n       (rts_n),
    .cts_s       (cts_s),
    .auto_cts_en (auto_cts_en),
    .flow_irq    (flow_irq),
    .mdm_cts_chg (mdm_cts_chg)
  );

endmodule

// File: rtl/uart_hfc_checker.sv
module uart_hfc_checker #(
  parameter int unsigned LVL_W      = 7,
  parameter int unsigned STEP_SHIFT = 2
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [LVL_W-1:0] rx_level,
  input logic [7:0]       thresh,
  input logic             auto_rts_en,
  input logic             rts_manual,
  input logic             auto_cts_en,
  input logic             tx_check,
  input logic             rts_n,
  input logic             tx_permit,
  input logic             flow_irq,
  input logic             mdm_cts_chg
);

  logic [LVL_W-1:0] chk_halt;
  logic [LVL_W-1:0] chk_resume;

  assign chk_halt   = LVL_W'(thresh[3:0]) << STEP_SHIFT;
  assign chk_resume = LVL_W'(thresh[7:4]) << STEP_SHIFT;

  a_r3_halt_deasserts: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (auto_rts_en && rx_level >= chk_halt) |=> rts_n);

  a_r4_resume_asserts: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (auto_rts_en && rx_level < chk_halt && rx_level <= chk_resume) |=> !rts_n);

  a_r4_window_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (auto_rts_en && $past(auto_rts_en) && rx_level < chk_halt && rx_level > chk_resume)
      |=> (rts_n == $past(rts_n)));

  a_r5_manual_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !auto_rts_en |=> (rts_n == !$past(rts_manual)));

  a_r6_permit_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (auto_cts_en && $past(auto_cts_en) && !$past(tx_check)) |-> $stable(tx_permit));

  a_r7_permit_free: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !auto_cts_en |-> tx_permit);

  a_r8_rts_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rts_n) |=> flow_irq);

  a_r9_chg_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    auto_cts_en |=> !mdm_cts_chg);

endmodule

bind uart_hfc_top uart_hfc_checker #(.LVL_W(LVL_W), .STEP_SHIFT(STEP_SHIFT)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .rx_level    (rx_level),
  .thresh      (thresh),
  .auto_rts_en (auto_rts_en),
  .rts_manual  (rts_manual),
  .auto_cts_en (auto_cts_en),
  .tx_check    (tx_check),
  .rts_n       (rts_n),
  .tx_permit   (tx_permit),
  .flow_irq    (flow_irq),
  .mdm_cts_chg (mdm_cts_chg)
);

// File: tb/uart_hfc_top_bench.sv
module uart_hfc_top_bench;

  localparam int LVL_W = 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LVL_W-1:0] rx_level;
  logic [7:0]       thresh;
  logic             auto_rts_en;
  logic             rts_manual;
  logic             auto_cts_en;
  logic             cts_n;
  logic             tx_check;
  logic             rts_n;
  logic             tx_permit;
  logic             flow_irq;
  logic             mdm_cts_chg;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  uart_hfc_top #(.LVL_W(LVL_W)) u_uart_hfc_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_level    (rx_level),
    .thresh      (thresh),
    .auto_rts_en (auto_rts_en),
    .rts_manual  (rts_manual),
    .auto_cts_en (auto_cts_en),
    .cts_n       (cts_n),
    .tx_check    (tx_check),
    .rts_n       (rts_n),
    .tx_permit   (tx_permit),
    .flow_irq    (flow_irq),
    .mdm_cts_chg (mdm_cts_chg)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rx_level = '0; thresh = 8'h00; auto_rts_en = 1'b0;
    rts_manual = 1'b0; auto_cts_en = 1'b0; cts_n = 1'b0; tx_check = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    chk(rts_n, 1'b1, "R1 rts_n after reset");
    chk(flow_irq, 1'b0, "R1 flow_irq after reset");
    chk(mdm_cts_chg, 1'b0, "R1 mdm_cts_chg after reset");
    chk(tx_permit, 1'b1, "R1 permit with auto-CTS off");
    auto_cts_en = 1'b1;
    #1;
    chk(tx_permit, 1'b0, "R1 permit before first check");
    auto_cts_en = 1'b0;
    tick(1);
  endtask

  task automatic t_manual;
    rts_manual = 1'b1;
    tick(1);
    chk(rts_n, 1'b0, "R5 manual 1 drives rts_n low");
    rts_manual = 1'b0;
    tick(1);
    chk(rts_n, 1'b1, "R5 manual 0 drives rts_n high");
    tick(1);
    chk(flow_irq, 1'b1, "R8 pulse on manual rts inactive");
    tick(1);
    chk(flow_irq, 1'b0, "R8 pulse is one cycle");
  endtask

  task automatic t_hyst;
    thresh = 8'h8F; auto_rts_en = 1'b1; rx_level = 7'd10;
    tick(1);
    chk(rts_n, 1'b0, "R3 below halt stays active");
    rx_level = 7'd59;
    tick(1);
    chk(rts_n, 1'b0, "R2 59 is below halt 60");
    rx_level = 7'd60;
    tick(1);
    chk(rts_n, 1'b1, "R3 halt at 60");
    tick(1);
    chk(flow_irq, 1'b1, "R8 pulse on auto halt");
    rx_level = 7'd45;
    tick(2);
    chk(rts_n, 1'b1, "R4 window keeps halted");
    rx_level = 7'd33;
    tick(1);
    chk(rts_n, 1'b1, "R2 33 above resume 32");
    rx_level = 7'd32;
    tick(1);
    chk(rts_n, 1'b0, "R4 resume at 32");
    rx_level = 7'd45;
    tick(2);
    chk(rts_n, 1'b0, "R4 window keeps active");
  endtask

  task automatic t_scale;
    thresh = 8'h2D; rx_level = 7'd51;
    tick(1);
    chk(rts_n, 1'b0, "R2 51 below halt 52");
    rx_level = 7'd52;
    tick(1);
    chk(rts_n, 1'b1, "R2 halt at 52");
    rx_level = 7'd9;
    tick(1);
    chk(rts_n, 1'b1, "R2 9 above resume 8");
    rx_level = 7'd8;
    tick(1);
    chk(rts_n, 1'b0, "R2 resume at 8");
  endtask

  task automatic t_flush;
    thresh = 8'h8F; rx_level = 7'd63;
    tick(1);
    chk(rts_n, 1'b1, "R10 halted before clear");
    rx_level = 7'd0;
    tick(1);
    chk(rts_n, 1'b0, "R10 clear reasserts next cycle");
  endtask

  task automatic t_cts_gate;
    cts_n = 1'b0; tx_check = 1'b0; auto_cts_en = 1'b1;
    tick(3);
    chk(tx_permit, 1'b0, "R6 no check keeps permit 0");
    tx_check = 1'b1;
    tick(1);
    chk(tx_permit, 1'b1, "R6 check with CTS active");
    tx_check = 1'b0; cts_n = 1'b1;
    tick(4);
    chk(tx_permit, 1'b1, "R6 CTS change between checks ignored");
    tx_check = 1'b1;
    tick(1);
    chk(tx_permit, 1'b0, "R6 check with CTS inactive");
    tx_check = 1'b0; cts_n = 1'b0;
    tick(4);
    chk(tx_permit, 1'b0, "R6 hold low until next check");
    chk(mdm_cts_chg, 1'b0, "R9 masked with auto-CTS on");
    auto_cts_en = 1'b0;
    #1;
    chk(tx_permit, 1'b1, "R7 auto-CTS off forces permit");
    cts_n = 1'b1; tx_check = 1'b1;
    tick(2);
    chk(tx_permit, 1'b1, "R7 permit ignores CTS");
    chk(flow_irq, 1'b0, "R8 no pulse before sync delay");
    tick(1);
    chk(flow_irq, 1'b1, "R8 pulse on CTS inactive");
    chk(mdm_cts_chg, 1'b1, "R9 CTS change reported");
    tick(1);
    chk(flow_irq, 1'b0, "R8 CTS pulse is one cycle");
    chk(mdm_cts_chg, 1'b0, "R9 report is one cycle");
    tx_check = 1'b0;
  endtask

  task automatic t_merge;
    cts_n = 1'b0; rx_level = 7'd10; thresh = 8'h8F; auto_rts_en = 1'b1;
    tick(5);
    chk(rts_n, 1'b0, "R8 setup rts active");
    cts_n = 1'b1;
    tick(1);
    rx_level = 7'd60;
    tick(1);
    chk(flow_irq, 1'b0, "R8 merge none early");
    tick(1);
    chk(flow_irq, 1'b1, "R8 merged pulse");
    tick(1);
    chk(flow_irq, 1'b0, "R8 merged single cycle");
  endtask

  initial begin
    t_reset();
    t_manual();
    t_hyst();
    t_scale();
    t_flush();
    t_cts_gate();
    t_merge();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule